// File: doc/BRIEF.md
# Bad-Line Character Row Fetcher

This block belongs to a raster video controller. At each raster line start it decides whether the line is a bad line, meaning a character row has to be fetched from memory. If it is, the block stalls the CPU, waits a short lead-in while the bus is handed over, and then reads one screen code and one 4-bit color value per cycle for 40 columns. Each read goes to a 10-bit video counter address that wraps. The results go into a line buffer, which the pixel logic reads through a random-access port.

A bad line also clears the character row counter, through a one-cycle pulse, and moves the display out of its idle state. Any fetch slot that does not get the bus stores a filler code and takes its color from the low nibble of the CPU data bus.

Top module: `badline_fetch`

## Requirements
- R1: After reset, `stall_o`, `mem_req_o`, `row_rst_o` and `display_o` are 0, and every buffer entry reads back as code 0x00 and color 0x0.
- R2: A `line_start_i` pulse accepted while idle starts a fetch when all three conditions hold: `raster_i[2:0]` equals `yscroll_i`, `den_i` is 1, and `first_line_i <= raster_i <= last_line_i`. Both window bounds are inclusive.
- R3: If any condition of R2 fails, the line start causes no stall, no memory request and no row reset, and the buffer is left as it was.
- R4: In the fetch, `mem_req_o` is high for exactly 40 consecutive cycles, always inside the stall. Slot c (0..39) drives `mem_addr_o = (vc_base_i + c) mod 1024`, where `vc_base_i` is sampled at the accepted line start, so the address runs on from 0x3FF to 0x000.
- R5: When `bus_grant_i` is 1 in slot c, buffer entry c stores `mem_rdata_i` as the code and `col_rdata_i` as the 4-bit color.
- R6: When `bus_grant_i` is 0 in slot c, entry c stores code 0xFF and color `cpu_lo_i`.
- R7: In the cycle after an accepted line start that starts a fetch, `row_rst_o` pulses high for one cycle and `display_o` becomes 1. `display_o` then stays 1.
- R8: `stall_o` rises in the cycle after the accepted line start and stays high for exactly 43 cycles: a 3-cycle lead-in followed by the 40 fetch slots.
- R9: A raster value is evaluated only once. Another `line_start_i` pulse carrying the same `raster_i` as the previous evaluation does nothing.
- R10: A `line_start_i` pulse that arrives while a fetch is running is ignored. The current fetch is neither restarted nor lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle pulse at the start of a raster line |
| raster_i | input | 9 | Current raster line |
| yscroll_i | input | 3 | Vertical fine scroll |
| den_i | input | 1 | Display-enable latch; bad lines are allowed when it is 1 |
| first_line_i | input | 9 | First line of the fetch window |
| last_line_i | input | 9 | Last line of the fetch window |
| vc_base_i | input | 10 | Video counter base for the row |
| mem_rdata_i | input | 8 | Screen code returned for `mem_addr_o` in the same cycle |
| col_rdata_i | input | 4 | Color value returned for `mem_addr_o` in the same cycle |
| bus_grant_i | input | 1 | The current slot owns the bus |
| cpu_lo_i | input | 4 | Low nibble of the CPU data bus |
| rd_idx_i | input | 6 | Buffer read column |
| mem_req_o | output | 1 | Fetch slot active |
| mem_addr_o | output | 10 | Matrix and color address |
| stall_o | output | 1 | CPU stall request |
| row_rst_o | output | 1 | Character row counter reset pulse |
| display_o | output | 1 | Display state; 0 means idle |
| rd_code_o | output | 8 | Buffered screen code at `rd_idx_i`; 0 when the index is 40 or more |
| rd_color_o | output | 4 | Buffered color at `rd_idx_i`; 0 when the index is 40 or more |

## Verification
Take E0 as the edge that samples the line start. `stall_o`, `row_rst_o` and `display_o` change in the cycle after E0. Fetch slot c occupies the cycle after edge E0+3+c, and buffer entry c is written at edge E0+4+c. The bench samples every output at the falling edge. It counts stall and row-reset cycles across a 60-cycle window after each line start, and a monitor pops one expected address per requested slot. The buffer is read back only after the window ends, when all 40 writes are done.

// File: rtl/badline_pkg.sv
package badline_pkg;
  localparam int unsigned DEF_COLS   = 40;
  localparam int unsigned DEF_LEAD   = 3;
  localparam int unsigned DEF_VC_W   = 10;
  localparam int unsigned DEF_LINE_W = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_FETCH
  } fetch_st_e;
endpackage

// File: rtl/badline_detect.sv
module badline_detect #(
  parameter int unsigned LINE_W = badline_pkg::DEF_LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic              busy_i,
  input  logic [LINE_W-1:0] raster_i,
  input  logic [2:0]        yscroll_i,
  input  logic              den_i,
  input  logic [LINE_W-1:0] first_line_i,
  input  logic [LINE_W-1:0] last_line_i,
  output logic              fire_o
);
  logic              seen_q;
  logic [LINE_W-1:0] last_q;
  logic              accept, repeat_line, cond;

  assign repeat_line = seen_q && (raster_i == last_q);
  assign accept      = line_start_i && !busy_i && !repeat_line;
  assign cond        = (raster_i[2:0] == yscroll_i) && den_i &&
                       (raster_i >= first_line_i) && (raster_i <= last_line_i);
  assign fire_o      = accept && cond;

  // evaluation is recorded whether or not the line turns out bad
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (accept) begin
      seen_q <= 1'b1;
      last_q <= raster_i;
    end
  end
endmodule

// File: rtl/badline_seq.sv
module badline_seq
  import badline_pkg::*;
#(
  parameter int unsigned COLS  = DEF_COLS,
  parameter int unsigned LEAD  = DEF_LEAD,
  parameter int unsigned VC_W  = DEF_VC_W,
  parameter int unsigned CNT_W = $clog2(COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [VC_W-1:0]  vc_base_i,
  output logic             busy_o,
  output logic             req_o,
  output logic [VC_W-1:0]  addr_o,
  output logic [CNT_W-1:0] slot_o,
  output logic             row_rst_o,
  output logic             display_o
);
  localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD - 1);
  localparam logic [CNT_W-1:0] COL_LAST  = CNT_W'(COLS - 1);

  fetch_st_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [VC_W-1:0]  vc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      vc_q      <= '0;
      row_rst_o <= 1'b0;
      display_o <= 1'b0;
    end else begin
      row_rst_o <= fire_i;
      if (fire_i) display_o <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (fire_i) begin
          st_q  <= ST_LEAD;
          cnt_q <= '0;
          vc_q  <= vc_base_i;
        end
        ST_LEAD: begin
          if (cnt_q == LEAD_LAST) begin
            st_q  <= ST_FETCH;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FETCH: begin
          if (cnt_q == COL_LAST) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign req_o  = (st_q == ST_FETCH);
  assign slot_o = cnt_q;
  // natural VC_W-bit wrap gives modulo 2**VC_W addressing
  assign addr_o = vc_q + {{(VC_W-CNT_W){1'b0}}, cnt_q};
endmodule

// File: rtl/badline_buf.sv
module badline_buf #(
  parameter int unsigned COLS  = badline_pkg::DEF_COLS,
  parameter int unsigned CNT_W = $clog2(COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_idx_i,
  input  logic             grant_i,
  input  logic [7:0]       code_i,
  input  logic [3:0]       color_i,
  input  logic [3:0]       cpu_lo_i,
  input  logic [CNT_W-1:0] rd_idx_i,
  output logic [7:0]       rd_code_o,
  output logic [3:0]       rd_color_o
);
  logic [7:0] code_q  [COLS];
  logic [3:0] color_q [COLS];
  logic [7:0] code_d;
  logic [3:0] color_d;

  // slot without the bus: filler code, color from the CPU bus
  assign code_d  = grant_i ? code_i  : 8'hFF;
  assign color_d = grant_i ? color_i : cpu_lo_i;

  for (genvar g = 0; g < COLS; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q[g]  <= '0;
        color_q[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == CNT_W'(g))) begin
        code_q[g]  <= code_d;
        color_q[g] <= color_d;
      end
    end
  end

  always_comb begin
    rd_code_o  = '0;
    rd_color_o = '0;
    for (int i = 0; i < COLS; i++) begin
      if (rd_idx_i == CNT_W'(i)) begin
        rd_code_o  = code_q[i];
        rd_color_o = color_q[i];
      end
    end
  end
endmodule

// File: rtl/badline_fetch.sv
module badline_fetch
  import badline_pkg::*;
#(
  parameter int unsigned COLS   = DEF_COLS,
  parameter int unsigned LEAD   = DEF_LEAD,
  parameter int unsigned VC_W   = DEF_VC_W,
  parameter int unsigned LINE_W = DEF_LINE_W,
  localparam int unsigned CNT_W = $clog2(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [LINE_W-1:0] raster_i,
  input  logic [2:0]        yscroll_i,
  input  logic              den_i,
  input  logic [LINE_W-1:0] first_line_i,
  input  logic [LINE_W-1:0] last_line_i,
  input  logic [VC_W-1:0]   vc_base_i,
  input  logic [7:0]        mem_rdata_i,
  input  logic [3:0]        col_rdata_i,
  input  logic              bus_grant_i,
  input  logic [3:0]        cpu_lo_i,
  input  logic [CNT_W-1:0]  rd_idx_i,
  output logic              mem_req_o,
  output logic [VC_W-1:0]   mem_addr_o,
  output logic              stall_o,
  output logic              row_rst_o,
  output logic              display_o,
  output logic [7:0]        rd_code_o,
  output logic [3:0]        rd_color_o
);
  logic             fire, busy;
  logic [CNT_W-1:0] slot;

  badline_detect #(.LINE_W(LINE_W)) i_detect (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .busy_i       (busy),
    .raster_i     (raster_i),
    .yscroll_i    (yscroll_i),
    .den_i        (den_i),
    .first_line_i (first_line_i),
    .last_line_i  (last_line_i),
    .fire_o       (fire)
  );

  badline_seq #(.COLS(COLS), .LEAD(LEAD), .VC_W(VC_W), .CNT_W(CNT_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .vc_base_i (vc_base_i),
    .busy_o    (busy),
    .req_o     (mem_req_o),
    .addr_o    (mem_addr_o),
    .slot_o    (slot),
    .row_rst_o (row_rst_o),
    .display_o (display_o)
  );

  badline_buf #(.COLS(COLS), .CNT_W(CNT_W)) i_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (mem_req_o),
    .wr_idx_i   (slot),
    .grant_i    (bus_grant_i),
    .code_i     (mem_rdata_i),
    .color_i    (col_rdata_i),
    .cpu_lo_i   (cpu_lo_i),
    .rd_idx_i   (rd_idx_i),
    .rd_code_o  (rd_code_o),
    .rd_color_o (rd_color_o)
  );

  assign stall_o = busy;
endmodule

// File: rtl/badline_fetch_chk.sv
module badline_fetch_chk #(
  parameter int unsigned COLS = badline_pkg::DEF_COLS,
  parameter int unsigned LEAD = badline_pkg::DEF_LEAD,
  parameter int unsigned VC_W = badline_pkg::DEF_VC_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_req_o,
  input logic [VC_W-1:0] mem_addr_o,
  input logic            stall_o,
  input logic            row_rst_o,
  input logic            display_o
);
  localparam int unsigned STALL_LEN = COLS + LEAD;
  localparam int unsigned RUN_W     = $clog2(STALL_LEN + 2);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      req_q <= '0;
    end else begin
      run_q <= stall_o   ? run_q + 1'b1 : '0;
      req_q <= mem_req_o ? req_q + 1'b1 : '0;
    end
  end

  // R8
  stall_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) |-> run_q == RUN_W'(STALL_LEN));
  // R8
  stall_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> run_q < RUN_W'(STALL_LEN));
  // R4
  req_in_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> stall_o);
  // R4
  req_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_req_o) |-> req_q == RUN_W'(COLS));
  // R4
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && $past(mem_req_o) |-> mem_addr_o == VC_W'($past(mem_addr_o) + 1'b1));
  // R7
  row_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_rst_o |=> !row_rst_o);
  // R7
  row_disp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_rst_o |-> display_o && $rose(stall_o));
  // R7
  disp_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(display_o));
endmodule

bind badline_fetch badline_fetch_chk #(.COLS(COLS), .LEAD(LEAD), .VC_W(VC_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .stall_o    (stall_o),
  .row_rst_o  (row_rst_o),
  .display_o  (display_o)
);

// File: tb/test_badline_fetch.sv
`timescale 1ns/1ps
module test_badline_fetch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start = 1'b0;
  logic [8:0] raster = '0;
  logic [2:0] yscroll = '0;
  logic       den = 1'b0;
  logic [8:0] first_line = 9'h030;
  logic [8:0] last_line = 9'h0F7;
  logic [9:0] vc_base = '0;
  logic [7:0] mem_rdata;
  logic [3:0] col_rdata;
  logic       bus_grant;
  logic [3:0] cpu_lo = 4'h7;
  logic [5:0] rd_idx = '0;
  logic       mem_req, stall, row_rst, display;
  logic [9:0] mem_addr;
  logic [7:0] rd_code;
  logic [3:0] rd_color;

  int n_chk = 0, n_fail = 0;
  int deny_n = 0;
  int slot_cnt = 0;
  logic [9:0] addr_q[$];
  logic [7:0] exp_code[40];
  logic [3:0] exp_col[40];

  always #5 clk = ~clk;

  badline_fetch i_badline_fetch (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(line_start), .raster_i(raster),
    .yscroll_i(yscroll), .den_i(den), .first_line_i(first_line), .last_line_i(last_line),
    .vc_base_i(vc_base), .mem_rdata_i(mem_rdata), .col_rdata_i(col_rdata),
    .bus_grant_i(bus_grant), .cpu_lo_i(cpu_lo), .rd_idx_i(rd_idx),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .stall_o(stall), .row_rst_o(row_rst),
    .display_o(display), .rd_code_o(rd_code), .rd_color_o(rd_color)
  );

  // memory model, same-cycle data
  assign mem_rdata = mem_addr[7:0] ^ 8'h5A;
  assign col_rdata = mem_addr[3:0] ^ mem_addr[9:6];
  assign bus_grant = (slot_cnt >= deny_n);

  always @(posedge clk) begin
    if (line_start) slot_cnt <= 0;
    else if (mem_req) slot_cnt <= slot_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: one expected address per requested slot
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (addr_q.size() == 0) chk(1'b0, "R3", "unexpected mem_req", 1, 0);
      else begin
        logic [9:0] e;
        e = addr_q.pop_front();
        chk(mem_addr == e, "R4", "mem_addr", mem_addr, e);
      end
    end
  end

  // driver: push expectations, pulse line start, observe stall/row reset
  task automatic run_line(input string req, input logic [8:0] r, input logic [2:0] ys,
                          input bit en, input logic [9:0] base, input int deny,
                          input bit bad, input bit mid);
    int n_stall = 0, n_row = 0, first_stall = -1;
    deny_n = deny;
    if (bad) begin
      for (int c = 0; c < 40; c++) begin
        logic [9:0] a;
        a = base + 10'(c);
        addr_q.push_back(a);
        exp_code[c] = (c < deny) ? 8'hFF : (a[7:0] ^ 8'h5A);
        exp_col[c]  = (c < deny) ? cpu_lo : (a[3:0] ^ a[9:6]);
      end
    end
    @(negedge clk);
    raster = r; yscroll = ys; den = en; vc_base = base; line_start = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (stall) begin
        n_stall++;
        if (first_stall < 0) first_stall = i;
      end
      if (row_rst) n_row++;
      if (i == 0 && bad) chk(display == 1'b1, "R7", "display after bad line", display, 1);
      line_start = (mid && i == 10);
      if (mid && i == 10) raster = r + 9'd8;
    end
    chk(n_stall == (bad ? 43 : 0), bad ? "R8" : req, "stall cycles", n_stall, bad ? 43 : 0);
    if (bad) chk(first_stall == 0, "R8", "stall start cycle", first_stall, 0);
    chk(n_row == (bad ? 1 : 0), bad ? "R7" : req, "row reset pulses", n_row, bad ? 1 : 0);
    chk(addr_q.size() == 0, "R4", "slots left unfetched", addr_q.size(), 0);
    addr_q.delete();
    // buffer must hold last good row either way (R3: untouched on non-bad line)
    for (int c = 0; c < 40; c++) begin
      rd_idx = 6'(c);
      #1;
      chk(rd_code == exp_code[c], deny > 0 ? "R6" : (bad ? "R5" : "R3"), "buffer code", rd_code, exp_code[c]);
      chk(rd_color == exp_col[c], deny > 0 ? "R6" : (bad ? "R5" : "R3"), "buffer color", rd_color, exp_col[c]);
    end
  endtask

  initial begin
    for (int c = 0; c < 40; c++) begin exp_code[c] = '0; exp_col[c] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!stall && !mem_req && !row_rst && !display, "R1", "reset outputs",
        {stall, mem_req, row_rst, display}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_idx = 6'd5; #1;
    chk(rd_code == 8'h00 && rd_color == 4'h0, "R1", "reset buffer", {rd_code, rd_color}, 0);
    rd_idx = 6'd45; #1;
    chk(rd_code == 8'h00, "R1", "out-of-range read", rd_code, 0);
    // R3 mismatching scroll before any bad line: display stays idle
    run_line("R3", 9'h034, 3'd3, 1'b1, 10'h000, 0, 1'b0, 1'b0);
    chk(display == 1'b0, "R3", "display stays idle", display, 0);
    // R2 plain bad line
    run_line("R2", 9'h033, 3'd3, 1'b1, 10'h028, 0, 1'b1, 1'b0);
    // R9 same raster again
    run_line("R9", 9'h033, 3'd3, 1'b1, 10'h100, 0, 1'b0, 1'b0);
    // R3 display-enable off, below and above window
    run_line("R3", 9'h03B, 3'd3, 1'b0, 10'h100, 0, 1'b0, 1'b0);
    run_line("R3", 9'h02B, 3'd3, 1'b1, 10'h100, 0, 1'b0, 1'b0);
    run_line("R3", 9'h0FB, 3'd3, 1'b1, 10'h100, 0, 1'b0, 1'b0);
    // R2 inclusive bounds
    first_line = 9'h043; last_line = 9'h04B;
    run_line("R2", 9'h043, 3'd3, 1'b1, 10'h200, 0, 1'b1, 1'b0);
    run_line("R2", 9'h04B, 3'd3, 1'b1, 10'h228, 0, 1'b1, 1'b0);
    first_line = 9'h030; last_line = 9'h0F7;
    // R4 wrap past 0x3FF
    run_line("R4", 9'h055, 3'd5, 1'b1, 10'h3F0, 0, 1'b1, 1'b0);
    // R6 first slots denied the bus
    run_line("R6", 9'h05D, 3'd5, 1'b1, 10'h0A0, 6, 1'b1, 1'b0);
    // R10 line start during a running fetch
    run_line("R10", 9'h065, 3'd5, 1'b1, 10'h150, 0, 1'b1, 1'b1);
    chk(display == 1'b1, "R7", "display stays set", display, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule